// File: doc/BRIEF.md
# Compacting Out-of-Order Issue Queue

This block holds up to 36 renamed operations waiting for execution and sends them to three execution pipes: add, multiply and store. Each cycle it can accept a group of up to three operations from the rename stage. Every operation carries two source tags, a destination tag and the pipe it needs. When an operation is written in, each of its sources is tied to one bus group. A source either watches the three result buses or the two load-operand buses, and never both. A source turns ready when a valid broadcast in its own group carries its tag.

Each pipe takes the lowest-indexed entry that is valid, fully ready and aimed at that pipe, provided the pipe reports itself free. Issued entries are removed by shifting every younger entry down, so the occupied slots always form a run starting at index 0 with the oldest operation first. Lowest-index selection is therefore oldest-first selection. New operations join at the tail, in lane order. A group that does not fit in the free slots is held back whole through the stall output.

Top module: `iq_sched`

## Requirements
- R1: After reset the queue is empty. No issue output is valid, and a full group of three operations is accepted without stall.
- R2: An entry issues only when it is resident, both of its sources are ready, and the free input of its pipe is high. An operation written in cycle t can issue in cycle t+1 at the earliest. Pipe codes are add=0, multiply=1, store=2, and each code is also the index of that pipe's issue port and free bit.
- R3: Each pipe issues at most one entry per cycle, and it takes the lowest-indexed (oldest) candidate. Different pipes can issue in the same cycle.
- R4: A source whose load flag is 0 becomes ready only on a matching valid result bus and ignores the load buses. A source whose flag is 1 becomes ready only on a matching valid load bus and ignores the result buses.
- R5: A broadcast in the same cycle as an insert marks the incoming source ready.
- R6: A broadcast in cycle t lets a waiting entry issue in cycle t+1, not in cycle t.
- R7: Issued entries leave the queue and the rest keep their age order. Valid lanes of an accepted group are appended behind the existing entries in increasing lane index, and invalid lanes leave no gap.
- R8: The stall output is high when the number of valid lanes exceeds 36 minus the occupancy at the start of the cycle. Issues in that cycle do not count as free. A stalled group is not written at all.
- R9: Exactly 36 operations fit. With 36 resident entries any insert of one or more operations stalls.
- R10: Each issue port carries the destination tag and both source tags of the issued entry. Source s of port p sits at bits [(p*2+s)*7 +: 7]. Lane k source s is laid out the same way on the insert port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 3 | Per-lane valid of the incoming group |
| ins_pipe | input | 6 | Per-lane pipe code (2 bits each) |
| ins_dst | input | 21 | Per-lane destination tag (7 bits each) |
| ins_src_tag | input | 42 | Per-lane, per-source tag |
| ins_src_load | input | 6 | Per-source group: 1 = load buses, 0 = result buses |
| ins_src_rdy | input | 6 | Per-source already-ready flag |
| ins_stall | output | 1 | Group does not fit and is not taken |
| res_valid | input | 3 | Result bus valids |
| res_tag | input | 21 | Result bus tags |
| ld_valid | input | 2 | Load bus valids |
| ld_tag | input | 14 | Load bus tags |
| pipe_free | input | 3 | Pipe can accept an operation this cycle |
| iss_valid | output | 3 | Issue valid per pipe |
| iss_dst | output | 21 | Destination tag per issue port |
| iss_src_tag | output | 42 | Source tags per issue port |

## Verification
The operations are inserted as single ready operations, as full groups of three for one pipe, and as mixed groups in which one entry waits on a tag. Together these separate correct age order from any other order and show that independent pipes issue together. Broadcasts arrive on the wrong group, on the right group one cycle ahead, and in the same cycle as the insert. These three patterns separate group filtering, wakeup latency and the insert-time bypass. A fill to exactly 36 uses a sparse two-lane group and rejected groups at 35 and 36 resident entries. Draining that fill one entry per cycle then shows whether packing and stall handling kept every accepted operation and dropped every rejected one.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int TAG_W  = 7;
  localparam int NSRC   = 2;
  localparam int NRES   = 3;
  localparam int NLD    = 2;
  localparam int NPIPE  = 3;
  localparam int PIPE_W = 2;

  typedef enum logic [PIPE_W-1:0] {
    PIPE_ADD = 2'd0,
    PIPE_MUL = 2'd1,
    PIPE_STO = 2'd2
  } pipe_e;

  typedef struct packed {
    logic [NSRC-1:0]            rdy;
    logic [NSRC-1:0]            on_load;
    logic [NSRC-1:0][TAG_W-1:0] tag;
    logic [TAG_W-1:0]           dst;
    logic [PIPE_W-1:0]          pipe;
    logic                       valid;
  } iq_entry_t;

  // Population count of an up-to-64-bit vector.
  function automatic int unsigned ones_count(input logic [63:0] v);
    int unsigned c;
    c = 0;
    for (int b = 0; b < 64; b++) c += int'(v[b]);
    return c;
  endfunction

  // True when a valid broadcast in the source's selected group carries its tag.
  function automatic logic tag_hit(
    input logic                       on_load,
    input logic [TAG_W-1:0]           t,
    input logic [NRES-1:0]            rv,
    input logic [NRES-1:0][TAG_W-1:0] rt,
    input logic [NLD-1:0]             lv,
    input logic [NLD-1:0][TAG_W-1:0]  lt);
    logic hit;
    hit = 1'b0;
    if (on_load) begin
      for (int b = 0; b < NLD; b++) hit |= lv[b] && (lt[b] == t);
    end else begin
      for (int b = 0; b < NRES; b++) hit |= rv[b] && (rt[b] == t);
    end
    return hit;
  endfunction
endpackage

// File: rtl/iq_wakeup.sv
module iq_wakeup
  import iq_pkg::*;
(
  input  iq_entry_t                  cur,
  input  logic [NRES-1:0]            res_v,
  input  logic [NRES-1:0][TAG_W-1:0] res_t,
  input  logic [NLD-1:0]             ld_v,
  input  logic [NLD-1:0][TAG_W-1:0]  ld_t,
  output iq_entry_t                  nxt
);
  always_comb begin
    nxt = cur;
    for (int s = 0; s < NSRC; s++) begin
      nxt.rdy[s] = cur.rdy[s] |
                   (cur.valid & tag_hit(cur.on_load[s], cur.tag[s], res_v, res_t, ld_v, ld_t));
    end
  end
endmodule

// File: rtl/iq_select.sv
module iq_select
  import iq_pkg::*;
#(
  parameter  int DEPTH = 36,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  iq_entry_t [DEPTH-1:0]             q,
  input  logic [NPIPE-1:0]                  pipe_free,
  output logic [NPIPE-1:0][DEPTH-1:0]       req,
  output logic [NPIPE-1:0][DEPTH-1:0]       grant,
  output logic [NPIPE-1:0][IDX_W-1:0]       gidx,
  output logic [NPIPE-1:0]                  gvalid
);
  always_comb begin
    req    = '0;
    grant  = '0;
    gidx   = '0;
    gvalid = '0;
    for (int p = 0; p < NPIPE; p++) begin
      for (int i = 0; i < DEPTH; i++) begin
        req[p][i] = q[i].valid && (q[i].pipe == PIPE_W'(p)) && (&q[i].rdy);
      end
      // scan from the top so the lowest requester is the last one kept
      for (int i = DEPTH - 1; i >= 0; i--) begin
        if (req[p][i]) gidx[p] = IDX_W'(i);
      end
      gvalid[p] = (|req[p]) && pipe_free[p];
      if (gvalid[p]) grant[p] = DEPTH'(1) << gidx[p];
    end
  end
endmodule

// File: rtl/iq_compact.sv
module iq_compact
  import iq_pkg::*;
#(
  parameter  int DEPTH = 36,
  parameter  int NINS  = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int SH_W  = $clog2(NPIPE + 1)
) (
  input  iq_entry_t [DEPTH-1:0] q,
  input  logic [DEPTH-1:0]      issued,
  input  iq_entry_t [NINS-1:0]  ln,
  input  logic                  accept,
  output iq_entry_t [DEPTH-1:0] nq
);
  logic [DEPTH-1:0]    keep;
  logic [SH_W-1:0]     shamt [DEPTH];
  logic [OCC_W-1:0]    rank  [NINS];
  logic [OCC_W-1:0]    n_keep;

  // slide distance of each entry = issued entries below it
  always_comb begin
    int unsigned acc;
    acc = 0;
    for (int j = 0; j < DEPTH; j++) begin
      keep[j]  = q[j].valid & ~issued[j];
      shamt[j] = SH_W'(acc);
      acc     += int'(issued[j]);
    end
    n_keep = OCC_W'(ones_count(64'(keep)));
  end

  // tail position of each valid lane among the valid lanes
  always_comb begin
    int unsigned r;
    r = 0;
    for (int k = 0; k < NINS; k++) begin
      rank[k] = OCC_W'(r);
      r      += int'(ln[k].valid);
    end
  end

  always_comb begin
    int j;
    nq = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int d = 0; d <= NPIPE; d++) begin
        j = i + d;
        if (j < DEPTH) begin
          if (keep[IDX_W'(j)] && shamt[IDX_W'(j)] == SH_W'(d)) nq[i] = q[IDX_W'(j)];
        end
      end
      for (int k = 0; k < NINS; k++) begin
        if (accept && ln[k].valid && (n_keep + rank[k]) == OCC_W'(i)) nq[i] = ln[k];
      end
    end
  end
endmodule

// File: rtl/iq_sched.sv
module iq_sched
  import iq_pkg::*;
#(
  parameter  int DEPTH = 36,
  parameter  int NINS  = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NINS-1:0]               ins_valid,
  input  logic [NINS*PIPE_W-1:0]        ins_pipe,
  input  logic [NINS*TAG_W-1:0]         ins_dst,
  input  logic [NINS*NSRC*TAG_W-1:0]    ins_src_tag,
  input  logic [NINS*NSRC-1:0]          ins_src_load,
  input  logic [NINS*NSRC-1:0]          ins_src_rdy,
  output logic                          ins_stall,
  input  logic [NRES-1:0]               res_valid,
  input  logic [NRES*TAG_W-1:0]         res_tag,
  input  logic [NLD-1:0]                ld_valid,
  input  logic [NLD*TAG_W-1:0]          ld_tag,
  input  logic [NPIPE-1:0]              pipe_free,
  output logic [NPIPE-1:0]              iss_valid,
  output logic [NPIPE*TAG_W-1:0]        iss_dst,
  output logic [NPIPE*NSRC*TAG_W-1:0]   iss_src_tag
);
  iq_entry_t [DEPTH-1:0] q, qw, nq;
  iq_entry_t [NINS-1:0]  lane, lw;
  logic [OCC_W-1:0]      occ, occ_next, n_in, n_iss, free_slots;
  logic                  accept;
  logic [DEPTH-1:0]      q_valid, issued;
  logic [NRES-1:0][TAG_W-1:0] res_t;
  logic [NLD-1:0][TAG_W-1:0]  ld_t;
  logic [NPIPE-1:0][DEPTH-1:0] req, grant;
  logic [NPIPE-1:0][IDX_W-1:0] gidx;
  logic [NPIPE-1:0]            gvalid;

  assign res_t = res_tag;
  assign ld_t  = ld_tag;

  // unpack insert lanes
  always_comb begin
    for (int k = 0; k < NINS; k++) begin
      lane[k].valid = ins_valid[k];
      lane[k].pipe  = ins_pipe[k*PIPE_W +: PIPE_W];
      lane[k].dst   = ins_dst[k*TAG_W +: TAG_W];
      for (int s = 0; s < NSRC; s++) begin
        lane[k].tag[s]     = ins_src_tag[(k*NSRC+s)*TAG_W +: TAG_W];
        lane[k].on_load[s] = ins_src_load[k*NSRC+s];
        lane[k].rdy[s]     = ins_src_rdy[k*NSRC+s];
      end
    end
  end

  // wakeup on resident entries and on incoming lanes
  for (genvar i = 0; i < DEPTH; i++) begin : g_wq
    iq_wakeup u_wk (.cur(q[i]), .res_v(res_valid), .res_t(res_t),
                    .ld_v(ld_valid), .ld_t(ld_t), .nxt(qw[i]));
  end
  for (genvar k = 0; k < NINS; k++) begin : g_wl
    iq_wakeup u_wk (.cur(lane[k]), .res_v(res_valid), .res_t(res_t),
                    .ld_v(ld_valid), .ld_t(ld_t), .nxt(lw[k]));
  end

  iq_select #(.DEPTH(DEPTH)) u_sel (
    .q(q), .pipe_free(pipe_free), .req(req), .grant(grant),
    .gidx(gidx), .gvalid(gvalid));

  always_comb begin
    issued = '0;
    for (int p = 0; p < NPIPE; p++) issued |= grant[p];
    for (int i = 0; i < DEPTH; i++) q_valid[i] = q[i].valid;
  end

  // occupancy arithmetic
  assign n_in       = OCC_W'(ones_count(64'(ins_valid)));
  assign n_iss      = OCC_W'(ones_count(64'(gvalid)));
  assign free_slots = OCC_W'(DEPTH) - occ;
  assign ins_stall  = n_in > free_slots;
  assign accept     = ~ins_stall;
  assign occ_next   = occ - n_iss + (accept ? n_in : '0);

  iq_compact #(.DEPTH(DEPTH), .NINS(NINS)) u_cmp (
    .q(qw), .issued(issued), .ln(lw), .accept(accept), .nq(nq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      occ <= '0;
    end else begin
      q   <= nq;
      occ <= occ_next;
    end
  end

  // issue ports
  always_comb begin
    iss_valid   = gvalid;
    iss_dst     = '0;
    iss_src_tag = '0;
    for (int p = 0; p < NPIPE; p++) begin
      if (gvalid[p]) begin
        iss_dst[p*TAG_W +: TAG_W] = q[gidx[p]].dst;
        for (int s = 0; s < NSRC; s++)
          iss_src_tag[(p*NSRC+s)*TAG_W +: TAG_W] = q[gidx[p]].tag[s];
      end
    end
  end

  // ---------------- assertions ----------------
  for (genvar p = 0; p < NPIPE; p++) begin : g_chk
    p_ready_on_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[p] |-> (pipe_free[p] && q[gidx[p]].valid && (&q[gidx[p]].rdy)
                        && q[gidx[p]].pipe == PIPE_W'(p)));
    p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant[p]));
    p_oldest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      gvalid[p] |-> ((req[p] & (grant[p] - DEPTH'(1))) == '0));
  end

  p_contig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (DEPTH'(q_valid + DEPTH'(1)) & q_valid) == '0);
  p_occ_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ) == $countones(q_valid));
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ins_stall |=> occ == ($past(occ) - $past(n_iss)));
endmodule

// File: tb/iq_sched_test.sv
module iq_sched_test;
  import iq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0]             ins_valid = '0;
  logic [NI*PIPE_W-1:0]      ins_pipe = '0;
  logic [NI*TAG_W-1:0]       ins_dst = '0;
  logic [NI*NSRC*TAG_W-1:0]  ins_src_tag = '0;
  logic [NI*NSRC-1:0]        ins_src_load = '0;
  logic [NI*NSRC-1:0]        ins_src_rdy = '0;
  logic                      ins_stall;
  logic [NRES-1:0]           res_valid = '0;
  logic [NRES*TAG_W-1:0]     res_tag = '0;
  logic [NLD-1:0]            ld_valid = '0;
  logic [NLD*TAG_W-1:0]      ld_tag = '0;
  logic [NPIPE-1:0]          pipe_free = '0;
  logic [NPIPE-1:0]          iss_valid;
  logic [NPIPE*TAG_W-1:0]    iss_dst;
  logic [NPIPE*NSRC*TAG_W-1:0] iss_src_tag;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_sched uut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_pipe(ins_pipe),
    .ins_dst(ins_dst), .ins_src_tag(ins_src_tag), .ins_src_load(ins_src_load),
    .ins_src_rdy(ins_src_rdy), .ins_stall(ins_stall), .res_valid(res_valid),
    .res_tag(res_tag), .ld_valid(ld_valid), .ld_tag(ld_tag), .pipe_free(pipe_free),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_src_tag(iss_src_tag));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  function automatic int dst_of(input int p);
    return iss_valid[p] ? int'(iss_dst[p*TAG_W +: TAG_W]) : -1;
  endfunction

  function automatic int src_of(input int p, input int s);
    return int'(iss_src_tag[(p*NSRC+s)*TAG_W +: TAG_W]);
  endfunction

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in;
    ins_valid = '0; ins_pipe = '0; ins_dst = '0; ins_src_tag = '0;
    ins_src_load = '0; ins_src_rdy = '0;
    res_valid = '0; res_tag = '0; ld_valid = '0; ld_tag = '0;
  endtask

  task automatic put(input int k, input int pipe, input int dst,
                     input int t0, input bit l0, input bit r0,
                     input int t1, input bit l1, input bit r1);
    ins_valid[k] = 1'b1;
    ins_pipe[k*PIPE_W +: PIPE_W] = PIPE_W'(pipe);
    ins_dst[k*TAG_W +: TAG_W] = TAG_W'(dst);
    ins_src_tag[(k*NSRC+0)*TAG_W +: TAG_W] = TAG_W'(t0);
    ins_src_tag[(k*NSRC+1)*TAG_W +: TAG_W] = TAG_W'(t1);
    ins_src_load[k*NSRC+0] = l0; ins_src_rdy[k*NSRC+0] = r0;
    ins_src_load[k*NSRC+1] = l1; ins_src_rdy[k*NSRC+1] = r1;
  endtask

  task automatic put_ready(input int k, input int pipe, input int dst);
    put(k, pipe, dst, 1, 1'b0, 1'b1, 2, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    pipe_free = 3'b111;
    ins_valid = 3'b111;
    #1;
    chk("R1", "stall after reset", int'(ins_stall), 0);
    chk("R1", "issue after reset", int'(iss_valid), 0);
    ins_valid = '0;
  endtask

  task automatic t_basic;
    pipe_free = 3'b111;
    put(0, 0, 5, 3, 1'b0, 1'b1, 4, 1'b0, 1'b1);
    #1;
    chk("R2", "no issue in insert cycle", int'(iss_valid), 0);
    cyc; clear_in; #1;
    chk("R2", "add issues next cycle", dst_of(0), 5);
    chk("R10", "src0 tag", src_of(0, 0), 3);
    chk("R10", "src1 tag", src_of(0, 1), 4);
    cyc; #1;
    chk("R7", "issued entry removed", int'(iss_valid), 0);
  endtask

  task automatic t_oldest;
    pipe_free = 3'b000;
    put_ready(0, 0, 10); put_ready(1, 0, 11); put_ready(2, 0, 12);
    cyc; clear_in;
    pipe_free = 3'b001;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R3", "oldest add first", dst_of(0), 10 + i);
      cyc;
    end
    #1;
    chk("R7", "queue drained", int'(iss_valid), 0);
  endtask

  task automatic t_groups;
    pipe_free = 3'b111;
    put(0, 1, 20, 40, 1'b0, 1'b0, 41, 1'b0, 1'b1);
    cyc; clear_in; #1;
    chk("R2", "waiting source blocks", int'(iss_valid[1]), 0);
    ld_valid[0] = 1'b1; ld_tag[0 +: TAG_W] = 7'd40;
    cyc; clear_in; #1;
    chk("R4", "load bus ignored by result source", int'(iss_valid[1]), 0);
    res_valid[2] = 1'b1; res_tag[2*TAG_W +: TAG_W] = 7'd40;
    #1;
    chk("R6", "no issue in broadcast cycle", int'(iss_valid[1]), 0);
    cyc; clear_in; #1;
    chk("R6", "issue cycle after broadcast", dst_of(1), 20);
    cyc;
    put(0, 2, 21, 50, 1'b1, 1'b0, 0, 1'b0, 1'b1);
    cyc; clear_in;
    res_valid[0] = 1'b1; res_tag[0 +: TAG_W] = 7'd50;
    cyc; clear_in; #1;
    chk("R4", "result bus ignored by load source", int'(iss_valid[2]), 0);
    ld_valid[1] = 1'b1; ld_tag[TAG_W +: TAG_W] = 7'd50;
    cyc; clear_in; #1;
    chk("R4", "load bus wakes load source", dst_of(2), 21);
    cyc; #1;
    chk("R7", "empty after groups", int'(iss_valid), 0);
  endtask

  task automatic t_same_cycle;
    pipe_free = 3'b111;
    put(1, 0, 22, 60, 1'b0, 1'b0, 61, 1'b1, 1'b0);
    res_valid[0] = 1'b1; res_tag[0 +: TAG_W] = 7'd60;
    ld_valid[0] = 1'b1;  ld_tag[0 +: TAG_W] = 7'd61;
    cyc; clear_in; #1;
    chk("R5", "bypassed wakeup at insert", dst_of(0), 22);
    cyc;
  endtask

  task automatic t_mixed;
    pipe_free = 3'b000;
    put_ready(0, 1, 30);
    put(1, 0, 31, 70, 1'b0, 1'b0, 71, 1'b0, 1'b1);
    put_ready(2, 2, 32);
    cyc; clear_in;
    put_ready(0, 0, 33);
    cyc; clear_in;
    pipe_free = 3'b111;
    res_valid[1] = 1'b1; res_tag[TAG_W +: TAG_W] = 7'd70;
    #1;
    chk("R3", "three pipes together", int'(iss_valid), 7);
    chk("R3", "add skips waiting older", dst_of(0), 33);
    chk("R10", "mul dst", dst_of(1), 30);
    chk("R10", "store dst", dst_of(2), 32);
    cyc; clear_in; #1;
    chk("R7", "survivor issues alone", int'(iss_valid), 1);
    chk("R7", "survivor tag", dst_of(0), 31);
    cyc;
    pipe_free = 3'b011;
    put_ready(0, 2, 34);
    cyc; clear_in; #1;
    chk("R2", "busy store pipe holds", int'(iss_valid[2]), 0);
    pipe_free = 3'b111; #1;
    chk("R2", "store issues when free", dst_of(2), 34);
    cyc;
  endtask

  task automatic t_capacity;
    pipe_free = 3'b000;
    for (int c = 0; c < 11; c++) begin
      put_ready(0, 0, 3*c); put_ready(1, 0, 3*c + 1); put_ready(2, 0, 3*c + 2);
      #1;
      chk("R8", "fill group fits", int'(ins_stall), 0);
      cyc; clear_in;
    end
    put_ready(0, 0, 33); put_ready(2, 0, 34);
    #1;
    chk("R8", "sparse pair fits at 33", int'(ins_stall), 0);
    cyc; clear_in;
    put_ready(0, 0, 100); put_ready(1, 0, 101); put_ready(2, 0, 102);
    #1;
    chk("R8", "three into one slot stalls", int'(ins_stall), 1);
    cyc; clear_in;
    put_ready(1, 0, 35);
    #1;
    chk("R9", "last slot accepted", int'(ins_stall), 0);
    cyc; clear_in;
    put_ready(0, 0, 103);
    #1;
    chk("R9", "full queue stalls", int'(ins_stall), 1);
    cyc; clear_in;
    pipe_free = 3'b001;
    for (int i = 0; i < 36; i++) begin
      #1;
      chk("R7", "drain order", dst_of(0), i);
      cyc;
    end
    #1;
    chk("R8", "no stalled op entered", int'(iss_valid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    report;
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_oldest;
    t_groups;
    t_same_cycle;
    t_mixed;
    t_capacity;
    report;
    $finish;
  end
endmodule